// File: doc/BRIEF.md
# Overcurrent Alert Hysteresis Monitor

This block sits behind an ADC that digitises a load-current monitor voltage. The ADC produces an 8-bit code in which 255 steps span the 3.3 V range, so one step is about 12.94 mV and half load reads 7Fh. The block keeps each valid code in a readable current register. It drives an active-low alert line that has separate assert and release thresholds. It also holds a sticky status flag that the host clears by reading it.

The alert goes low when a sampled code reaches the assert threshold, 255 by default. It stays low until a later sample is at or below the release threshold, 242 by default. Samples between the two thresholds leave the alert as it is. The status flag is set together with the alert. It clears only on a status read strobe, and only if the stored code is at or below the release threshold at that moment. The host sees the value the status had before any clear takes effect. A new set in the same cycle as a clear takes priority over the clear.

Top module: `ocmon_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `alert_n` is 1, `status_byte` is 00h and `cur_code` is 00h.
- R2: A cycle with `smp_valid` high loads `smp_code` into `cur_code` on the next cycle. `cur_code` holds its value while `smp_valid` is low, whatever `smp_code` carries.
- R3: A valid sample with a code of 255 or more drives `alert_n` to 0 on the next cycle.
- R4: When `alert_n` is low, a valid sample at or below 242 returns it to 1 on the next cycle. A valid sample from 243 to 254 leaves `alert_n` unchanged, whether it is high or low.
- R5: A valid sample of 255 sets bit 2 of `status_byte` to 1 on the next cycle.
- R6: Bit 2 of `status_byte` clears on the cycle after `stat_rd` is high, but only if `cur_code` is at or below 242 in the read cycle. If `cur_code` is above 242, the bit stays set. During the read cycle `status_byte` still shows the value from before the clear.
- R7: If a valid 255 sample and a qualifying read occur in the same cycle, bit 2 stays 1.
- R8: Bits 7..3 and 1..0 of `status_byte` always read 0.
- R9: While `smp_valid` is low, `alert_n` holds its value, and bit 2 of `status_byte` changes only through R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: `smp_code` holds a new ADC sample |
| smp_code | input | 8 | Load-current code from the ADC |
| stat_rd | input | 1 | Strobe: the host is reading the status register |
| alert_n | output | 1 | Active-low overcurrent alert |
| cur_code | output | 8 | Last valid sample code |
| status_byte | output | 8 | Status register; bit 2 is the sticky overcurrent flag |

## Verification
The bench builds the block with its default parameters: an 8-bit code, an assert threshold of 255 and a release threshold of 242. With these values all 256 codes can be swept from both alert states, so every point of the hysteresis band and both band edges are checked directly. The defaults also put the simultaneous-set-and-clear case and the read-while-still-high case on exact codes that the bench can drive.

// File: rtl/ocmon_pkg.sv
package ocmon_pkg;

  localparam int CODE_W_DEF     = 8;
  localparam int SET_CODE_DEF   = 255;
  localparam int REL_CODE_DEF   = 242;
  localparam int STATUS_W_DEF   = 8;
  localparam int STATUS_BIT_DEF = 2;

  typedef enum logic {
    ALR_CLEAR  = 1'b0,
    ALR_ACTIVE = 1'b1
  } alr_state_e;

endpackage

// File: rtl/ocmon_sample_reg.sv
module ocmon_sample_reg #(
  parameter int CODE_W = ocmon_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] stored
);

  logic [CODE_W-1:0] stored_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored_q <= '0;
    end else if (valid) begin
      stored_q <= code;
    end
  end

  assign stored = stored_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    valid |=> (stored == $past(code)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(stored));

endmodule

// File: rtl/ocmon_alert.sv
module ocmon_alert
  import ocmon_pkg::*;
#(
  parameter int CODE_W   = CODE_W_DEF,
  parameter int SET_CODE = SET_CODE_DEF,
  parameter int REL_CODE = REL_CODE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic              alert_n
);

  localparam logic [CODE_W-1:0] SET_V = CODE_W'(SET_CODE);
  localparam logic [CODE_W-1:0] REL_V = CODE_W'(REL_CODE);

  alr_state_e state_q, state_d;
  logic       hit_set, hit_rel;

  assign hit_set = (code >= SET_V);
  assign hit_rel = (code <= REL_V);

  always_comb begin
    state_d = state_q;
    if (valid) begin
      if (hit_set) begin
        state_d = ALR_ACTIVE;
      end else if (hit_rel) begin
        state_d = ALR_CLEAR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ALR_CLEAR;
    end else begin
      state_q <= state_d;
    end
  end

  assign alert_n = (state_q == ALR_CLEAR);

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && code >= SET_V) |=> !alert_n);

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && code <= REL_V) |=> alert_n);

  assert_band_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && code > REL_V && code < SET_V) |=> $stable(alert_n));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(alert_n));

endmodule

// File: rtl/ocmon_status.sv
module ocmon_status
  import ocmon_pkg::*;
#(
  parameter int CODE_W     = CODE_W_DEF,
  parameter int SET_CODE   = SET_CODE_DEF,
  parameter int REL_CODE   = REL_CODE_DEF,
  parameter int STATUS_W   = STATUS_W_DEF,
  parameter int STATUS_BIT = STATUS_BIT_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [CODE_W-1:0]   code,
  input  logic [CODE_W-1:0]   stored,
  input  logic                rd,
  output logic [STATUS_W-1:0] status
);

  localparam logic [CODE_W-1:0] SET_V = CODE_W'(SET_CODE);
  localparam logic [CODE_W-1:0] REL_V = CODE_W'(REL_CODE);

  logic flag_q;
  logic set_evt, clr_evt;

  assign set_evt = valid && (code >= SET_V);
  assign clr_evt = rd && (stored <= REL_V);

  // A set arriving in the same cycle as a qualifying clear takes priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
    end else if (clr_evt) begin
      flag_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < STATUS_W; i++) begin : g_bits
    if (i == STATUS_BIT) begin : g_flag
      assign status[i] = flag_q;
    end else begin : g_rsvd
      assign status[i] = 1'b0;
    end
  end

  assert_set_R5: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> status[STATUS_BIT]);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rd && stored <= REL_V && !set_evt) |=> !status[STATUS_BIT]);

  assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (status[STATUS_BIT] && !(rd && stored <= REL_V)) |=> status[STATUS_BIT]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_evt && rd) |=> status[STATUS_BIT]);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    (!status[STATUS_BIT] && !set_evt) |=> !status[STATUS_BIT]);

endmodule

// File: rtl/ocmon_top.sv
module ocmon_top
  import ocmon_pkg::*;
#(
  parameter int CODE_W     = CODE_W_DEF,
  parameter int SET_CODE   = SET_CODE_DEF,
  parameter int REL_CODE   = REL_CODE_DEF,
  parameter int STATUS_W   = STATUS_W_DEF,
  parameter int STATUS_BIT = STATUS_BIT_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [CODE_W-1:0]   smp_code,
  input  logic                stat_rd,
  output logic                alert_n,
  output logic [CODE_W-1:0]   cur_code,
  output logic [STATUS_W-1:0] status_byte
);

  logic [CODE_W-1:0] stored_code;

  ocmon_sample_reg #(.CODE_W(CODE_W)) u_sample (
    .clk    (clk),
    .rst    (rst),
    .valid  (smp_valid),
    .code   (smp_code),
    .stored (stored_code)
  );

  ocmon_alert #(
    .CODE_W   (CODE_W),
    .SET_CODE (SET_CODE),
    .REL_CODE (REL_CODE)
  ) u_alert (
    .clk     (clk),
    .rst     (rst),
    .valid   (smp_valid),
    .code    (smp_code),
    .alert_n (alert_n)
  );

  ocmon_status #(
    .CODE_W     (CODE_W),
    .SET_CODE   (SET_CODE),
    .REL_CODE   (REL_CODE),
    .STATUS_W   (STATUS_W),
    .STATUS_BIT (STATUS_BIT)
  ) u_status (
    .clk    (clk),
    .rst    (rst),
    .valid  (smp_valid),
    .code   (smp_code),
    .stored (stored_code),
    .rd     (stat_rd),
    .status (status_byte)
  );

  assign cur_code = stored_code;

  assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
    (status_byte & ~(STATUS_W'(1) << STATUS_BIT)) == '0);

  assert_alert_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !alert_n |-> status_byte[STATUS_BIT]);

endmodule

// File: tb/ocmon_top_bench.sv
module ocmon_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_code = 8'h00;
  logic       stat_rd = 1'b0;
  logic       alert_n;
  logic [7:0] cur_code;
  logic [7:0] status_byte;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ocmon_top u_ocmon_top (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .smp_code    (smp_code),
    .stat_rd     (stat_rd),
    .alert_n     (alert_n),
    .cur_code    (cur_code),
    .status_byte (status_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One valid sample; results are checked at the following negedge.
  task automatic sample(input logic [7:0] c);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = c;
    @(negedge clk);
    smp_valid = 1'b0;
    smp_code  = ~c;
  endtask

  task automatic read_status(output logic [7:0] seen);
    @(negedge clk);
    stat_rd = 1'b1;
    seen    = status_byte;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 alert_n", int'(alert_n), 1);
    chk("R1 status", int'(status_byte), 0);
    chk("R1 cur_code", int'(cur_code), 0);
  endtask

  task automatic t_capture();
    sample(8'h7F);
    chk("R2 capture 7Fh", int'(cur_code), 8'h7F);
    chk("R2 half load no alert", int'(alert_n), 1);
    repeat (3) @(negedge clk);
    chk("R2 hold without valid", int'(cur_code), 8'h7F);
    sample(8'h00);
    chk("R2 capture 00h", int'(cur_code), 0);
  endtask

  task automatic t_hysteresis();
    sample(8'd254);
    chk("R4 254 keeps high", int'(alert_n), 1);
    chk("R8 status clean", int'(status_byte), 0);
    sample(8'd255);
    chk("R3 255 asserts", int'(alert_n), 0);
    chk("R5 status bit2 set", int'(status_byte), 8'h04);
    sample(8'd250);
    chk("R4 250 keeps low", int'(alert_n), 0);
    sample(8'd243);
    chk("R4 243 keeps low", int'(alert_n), 0);
    repeat (4) @(negedge clk);
    chk("R9 idle keeps low", int'(alert_n), 0);
    chk("R9 idle keeps status", int'(status_byte), 8'h04);
    sample(8'd242);
    chk("R4 242 releases", int'(alert_n), 1);
    chk("R6 no read, still set", int'(status_byte), 8'h04);
    sample(8'd250);
    chk("R4 250 keeps high", int'(alert_n), 1);
  endtask

  task automatic t_status_clear();
    logic [7:0] seen;
    do_reset();
    sample(8'd255);
    sample(8'd250);
    read_status(seen);
    chk("R6 read shows set", int'(seen), 8'h04);
    chk("R6 read above 242 keeps bit", int'(status_byte), 8'h04);
    sample(8'd242);
    read_status(seen);
    chk("R6 read shows pre-clear value", int'(seen), 8'h04);
    chk("R6 read at 242 clears", int'(status_byte), 0);
    read_status(seen);
    chk("R6 read after clear", int'(seen), 0);
  endtask

  task automatic t_set_wins();
    do_reset();
    sample(8'd255);
    sample(8'd100);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = 8'd255;
    stat_rd   = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    stat_rd   = 1'b0;
    chk("R7 set beats clear", int'(status_byte), 8'h04);
    chk("R8 reserved bits zero", int'(status_byte & 8'hFB), 0);
    chk("R3 alert low", int'(alert_n), 0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 256; c++) begin
      sample(8'd255);
      sample(8'(c));
      chk("R4 sweep from low", int'(alert_n), (c <= 242) ? 1 : 0);
      sample(8'd0);
      sample(8'(c));
      chk("R3 sweep from high", int'(alert_n), (c == 255) ? 0 : 1);
    end
  endtask

  initial begin
    t_reset();
    t_capture();
    t_hysteresis();
    t_status_clear();
    t_set_wins();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule